// File: doc/BRIEF.md
# GPIO Port Drive-Mode Controller

This block controls one port of general-purpose pins, eight by default. Software reaches it over a simple synchronous register bus. Five registers are visible: an output data word, two mode bit-planes, a per-pin interrupt enable and a small configuration word. The configuration word carries a regulator-enable bit, which the block only stores and presents, and an interrupt trigger-select bit.

Each pin's drive mode is two bits wide, and one bit comes from each of the two bit-planes at that pin's own bit position. The mode and the pin's data bit together decide the registered pad controls for that pin: strong-high drive, strong-low drive, pull-up and input-buffer enable. After reset every pin sits in the analog high-impedance mode.

Pad inputs are synchronized before use. A read of the data address returns the synchronized inputs, and pins in analog mode read as zero. One port interrupt is formed from the enabled, non-analog pins, either as a level or as a one-cycle pulse on any change. It is gated by a global mask input.

Top module: `gpio_port_ctl`

## Requirements
- R1: After a synchronous reset, plane 1 (address 2) holds all ones and plane 0 (address 1), data (address 0 stored value), interrupt enable (address 3) and config (address 4) hold zero. Every pin is in mode 2'b10, all pad controls are low, and port_irq is low.
- R2: A pin's mode is {plane1[n], plane0[n]}. In mode 2'b00, data 1 gives pull-up only and data 0 gives strong-low only, with the input buffer enabled.
- R3: In mode 2'b01, data 1 gives strong-high only and data 0 gives strong-low only, with the input buffer enabled. Strong-high never coincides with strong-low or with pull-up.
- R4: In mode 2'b10, no drive or pull-up is active and the input buffer is disabled.
- R5: In mode 2'b11, data 1 drives nothing, data 0 gives strong-low only, and the input buffer is enabled.
- R6: The pad control outputs are registered. They reflect the register contents held before the clock edge, so they follow a write at the second rising edge after it.
- R7: bus_rdata is registered from bus_addr at each rising edge. Addresses 1, 2 and 3 return the stored words. Address 4 returns the config word in bits 1:0 and zero above.
- R8: A read of address 0 returns the pad inputs after a two-flop synchronizer, with every pin in mode 2'b10 forced to 0.
- R9: With config bit 0 clear, port_irq is registered as the global mask ANDed with the OR over pins of enable, non-analog and synchronized input.
- R10: With config bit 0 set, port_irq pulses for one cycle when an enabled, non-analog pin's synchronized input differs from its value one cycle earlier, while the global mask is high.
- R11: With the global mask low, port_irq is low in the following cycle. A pin with its enable clear, or in mode 2'b10, never contributes to port_irq.
- R12: Config bit 1 is presented on rail_reg_en in the cycle after it is written.
- R13: Writes to addresses 5 to 7 change no register, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad input levels |
| gpio_irq_mask | input | 1 | Global GPIO interrupt mask |
| pad_drv_hi | output | 8 | Strong-high drive enables |
| pad_drv_lo | output | 8 | Strong-low drive enables |
| pad_pull_up | output | 8 | Resistive pull-up enables |
| pad_in_en | output | 8 | Digital input buffer enables |
| port_irq | output | 1 | Combined port interrupt request |
| rail_reg_en | output | 1 | Stored output-regulator enable |

## Verification
Two functions can collide in one cycle. A mode write can move a pin into or out of analog mode in the same cycle that its synchronized input changes, and a register can be written at the same address that is being read. The bench produces both on purpose. It writes the mode planes while the pad inputs are toggling under change-triggered interrupts, and it holds bus_addr on a register while writing it. A behavioural model advances once per clock and decides which of the colliding effects is visible, and in which cycle. Every output is compared against that model at each falling edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_PULL   = 2'b00,
    MODE_STRONG = 2'b01,
    MODE_ANALOG = 2'b10,
    MODE_OPEN   = 2'b11
  } drive_mode_e;

  localparam int ADDR_DATA   = 0;
  localparam int ADDR_PLANE0 = 1;
  localparam int ADDR_PLANE1 = 2;
  localparam int ADDR_IE     = 3;
  localparam int ADDR_CFG    = 4;

  localparam int CFG_W       = 2;
  localparam int CFG_EDGE    = 0;
  localparam int CFG_REGEN   = 1;
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     data_q,
  output logic [W-1:0]     plane0_q,
  output logic [W-1:0]     plane1_q,
  output logic [W-1:0]     ie_q,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      plane0_q <= '0;
      plane1_q <= '1;
      ie_q     <= '0;
      cfg_q    <= '0;
    end else if (wr) begin
      case (int'(addr))
        ADDR_DATA:   data_q   <= wdata;
        ADDR_PLANE0: plane0_q <= wdata;
        ADDR_PLANE1: plane1_q <= wdata;
        ADDR_IE:     ie_q     <= wdata;
        ADDR_CFG:    cfg_q    <= wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data,
  input  logic [W-1:0] plane0,
  input  logic [W-1:0] plane1,
  output logic [W-1:0] drv_hi,
  output logic [W-1:0] drv_lo,
  output logic [W-1:0] pull_up,
  output logic [W-1:0] in_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    drive_mode_e mode;
    logic hi_d, lo_d, pu_d, ie_d;

    assign mode = drive_mode_e'({plane1[i], plane0[i]});

    always_comb begin
      hi_d = 1'b0;
      lo_d = 1'b0;
      pu_d = 1'b0;
      ie_d = 1'b1;
      case (mode)
        MODE_PULL: begin
          pu_d = data[i];
          lo_d = ~data[i];
        end
        MODE_STRONG: begin
          hi_d = data[i];
          lo_d = ~data[i];
        end
        MODE_OPEN: begin
          lo_d = ~data[i];
        end
        default: begin
          ie_d = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        drv_hi[i]  <= 1'b0;
        drv_lo[i]  <= 1'b0;
        pull_up[i] <= 1'b0;
        in_en[i]   <= 1'b0;
      end else begin
        drv_hi[i]  <= hi_d;
        drv_lo[i]  <= lo_d;
        pull_up[i] <= pu_d;
        in_en[i]   <= ie_d;
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign synced = stage[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= synced;
  end
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] synced,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] enable,
  input  logic [W-1:0] usable,
  input  logic         edge_mode,
  input  logic         gmask,
  output logic         irq
);
  logic [W-1:0] gate;
  logic [W-1:0] trig;

  assign gate = enable & usable;
  assign trig = edge_mode ? (synced ^ prev) : synced;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gmask & (|(gate & trig));
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  input  logic          gpio_irq_mask,
  output logic [W-1:0]  pad_drv_hi,
  output logic [W-1:0]  pad_drv_lo,
  output logic [W-1:0]  pad_pull_up,
  output logic [W-1:0]  pad_in_en,
  output logic          port_irq,
  output logic          rail_reg_en
);
  localparam int SYNC_STAGES = 2;

  logic [W-1:0]     data_q, plane0_q, plane1_q, ie_q;
  logic [CFG_W-1:0] cfg_q;
  logic [W-1:0]     synced, prev, usable;

  gpio_reg_bank #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .data_q(data_q), .plane0_q(plane0_q), .plane1_q(plane1_q),
    .ie_q(ie_q), .cfg_q(cfg_q)
  );

  gpio_pin_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .data(data_q), .plane0(plane0_q), .plane1(plane1_q),
    .drv_hi(pad_drv_hi), .drv_lo(pad_drv_lo), .pull_up(pad_pull_up),
    .in_en(pad_in_en)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(pad_in), .synced(synced), .prev(prev)
  );

  // pins outside analog mode (plane1=1, plane0=0) have a live input
  assign usable = ~(plane1_q & ~plane0_q);

  gpio_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .synced(synced), .prev(prev), .enable(ie_q),
    .usable(usable), .edge_mode(cfg_q[CFG_EDGE]), .gmask(gpio_irq_mask),
    .irq(port_irq)
  );

  assign rail_reg_en = cfg_q[CFG_REGEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (int'(bus_addr))
        ADDR_DATA:   bus_rdata <= synced & usable;
        ADDR_PLANE0: bus_rdata <= plane0_q;
        ADDR_PLANE1: bus_rdata <= plane1_q;
        ADDR_IE:     bus_rdata <= ie_q;
        ADDR_CFG:    bus_rdata <= {{(W-CFG_W){1'b0}}, cfg_q};
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_write,
  input logic         regen_wbit,
  input logic         gpio_irq_mask,
  input logic [W-1:0] pad_drv_hi,
  input logic [W-1:0] pad_drv_lo,
  input logic [W-1:0] pad_pull_up,
  input logic [W-1:0] pad_in_en,
  input logic         port_irq,
  input logic         rail_reg_en
);
  // R1: reset puts every pin in analog mode with the interrupt quiet
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pad_in_en == '0 && pad_drv_hi == '0 && pad_drv_lo == '0 &&
             pad_pull_up == '0 && !port_irq));

  // R3: strong-high never overlaps strong-low or pull-up
  p_no_fight_r3: assert property (@(posedge clk) disable iff (rst)
    ((pad_drv_hi & pad_drv_lo) == '0) && ((pad_drv_hi & pad_pull_up) == '0));

  // R4: a pin with its input buffer off drives nothing
  p_analog_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ((pad_drv_hi | pad_drv_lo | pad_pull_up) & ~pad_in_en) == '0);

  // R11: global mask low silences the interrupt one cycle later
  p_mask_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !gpio_irq_mask |=> !port_irq);

  // R12: regulator enable follows a config write
  p_regen_follow_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_write |=> (rail_reg_en == $past(regen_wbit)));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst),
  .cfg_write(bus_wr && (int'(bus_addr) == gpio_port_pkg::ADDR_CFG)),
  .regen_wbit(bus_wdata[gpio_port_pkg::CFG_REGEN]),
  .gpio_irq_mask(gpio_irq_mask),
  .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo),
  .pad_pull_up(pad_pull_up), .pad_in_en(pad_in_en),
  .port_irq(port_irq), .rail_reg_en(rail_reg_en)
);

// File: tb/gpio_port_ctl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic       gpio_irq_mask = 1'b0;
  logic [7:0] pad_drv_hi, pad_drv_lo, pad_pull_up, pad_in_en;
  logic       port_irq, rail_reg_en;

  always #2.5 clk = ~clk;

  gpio_port_ctl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .gpio_irq_mask(gpio_irq_mask), .pad_drv_hi(pad_drv_hi),
    .pad_drv_lo(pad_drv_lo), .pad_pull_up(pad_pull_up),
    .pad_in_en(pad_in_en), .port_irq(port_irq), .rail_reg_en(rail_reg_en)
  );

  int    checks = 0;
  int    bad = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] m_data, m_p0, m_p1, m_ie;
  logic [1:0] m_cfg;
  logic [7:0] m_s1, m_s2, m_prev;
  logic [7:0] e_hi, e_lo, e_pu, e_ien, e_rdata;
  logic       e_irq, e_regen;

  always @(posedge clk) begin
    if (rst) begin
      m_data = 0; m_p0 = 0; m_p1 = 8'hFF; m_ie = 0; m_cfg = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      e_hi = 0; e_lo = 0; e_pu = 0; e_ien = 0; e_rdata = 0; e_irq = 0;
      started = 1;
    end else begin
      logic [7:0] live;
      bit hit;
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        int md;
        md = {m_p1[i], m_p0[i]};
        live[i] = (md != 2);
        e_hi[i]  = (md == 1) && m_data[i];
        e_pu[i]  = (md == 0) && m_data[i];
        e_lo[i]  = (md != 2) && !m_data[i];
        e_ien[i] = (md != 2);
        if (m_ie[i] && live[i]) begin
          if (m_cfg[0] ? (m_s2[i] != m_prev[i]) : m_s2[i]) hit = 1;
        end
      end
      e_irq = gpio_irq_mask && hit;
      case (bus_addr)
        0: e_rdata = m_s2 & live;
        1: e_rdata = m_p0;
        2: e_rdata = m_p1;
        3: e_rdata = m_ie;
        4: e_rdata = {6'd0, m_cfg};
        default: e_rdata = 0;
      endcase
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      if (bus_wr) begin
        case (bus_addr)
          0: m_data = bus_wdata;
          1: m_p0 = bus_wdata;
          2: m_p1 = bus_wdata;
          3: m_ie = bus_wdata;
          4: m_cfg = bus_wdata[1:0];
          default: ;
        endcase
      end
    end
    e_regen = m_cfg[1];
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("drv_hi", pad_drv_hi, e_hi);
      chk("drv_lo", pad_drv_lo, e_lo);
      chk("pull_up", pad_pull_up, e_pu);
      chk("in_en", pad_in_en, e_ien);
      chk("rdata", bus_rdata, e_rdata);
      chk("irq", port_irq, e_irq);
      chk("reg_en", rail_reg_en, e_regen);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_addr = a[2:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a);
    bus_addr = a[2:0];
    idle(2);
  endtask

  initial begin
    idle(1);
    cur_req = "R1";
    idle(3);
    rst = 1'b0;
    rd(2); rd(1); rd(4); rd(3);

    cur_req = "R7";
    wr(1, 8'h5A); rd(1);
    wr(3, 8'hC3); rd(3);
    wr(4, 8'hFF); rd(4);
    wr(4, 8'h00);
    bus_addr = 3'd2;
    wr(2, 8'h96); idle(2);

    cur_req = "R2";
    wr(2, 8'h00); wr(1, 8'h00); wr(0, 8'hA5); idle(3);
    wr(0, 8'h5A); idle(3);
    cur_req = "R3";
    wr(1, 8'hFF); wr(0, 8'hF0); idle(3);
    wr(0, 8'h0F); idle(3);
    cur_req = "R5";
    wr(2, 8'hFF); idle(3);
    wr(0, 8'hFF); idle(3);
    cur_req = "R4";
    wr(1, 8'h00); idle(3);
    cur_req = "R6";
    wr(2, 8'b0011_0011); wr(1, 8'b0101_0101);
    wr(0, 8'hF0); idle(2); wr(0, 8'h0F); idle(3);

    cur_req = "R8";
    bus_addr = 3'd0;
    pad_in = 8'hFF; idle(4);
    pad_in = 8'h3C; idle(1); pad_in = 8'hC3; idle(4);
    wr(2, 8'h00); bus_addr = 3'd0; idle(3);

    cur_req = "R9";
    gpio_irq_mask = 1'b1;
    wr(3, 8'h0F);
    pad_in = 8'h00; idle(4);
    pad_in = 8'h10; idle(4);
    pad_in = 8'h04; idle(4);
    pad_in = 8'h00; idle(4);

    cur_req = "R10";
    wr(4, 8'h01);
    pad_in = 8'h01; idle(4);
    pad_in = 8'h00; idle(4);
    pad_in = 8'h80; idle(4);
    for (int k = 0; k < 6; k++) begin
      pad_in = pad_in ^ 8'h02; idle(1);
    end
    idle(3);
    // mode write into analog while input toggles
    pad_in = 8'h03;
    wr(2, 8'h01); idle(4);
    pad_in = 8'h00; wr(2, 8'h00); idle(4);

    cur_req = "R11";
    gpio_irq_mask = 1'b0;
    pad_in = 8'hFF; idle(4);
    gpio_irq_mask = 1'b1; idle(2);
    wr(4, 8'h00); idle(2);
    wr(3, 8'h00); idle(3);
    wr(3, 8'hFF); wr(2, 8'hFF); wr(1, 8'h00); idle(4);
    wr(3, 8'h00); wr(2, 8'h00);

    cur_req = "R12";
    wr(4, 8'h02); idle(2);
    wr(4, 8'h01); idle(2);
    wr(4, 8'h03); idle(2);

    cur_req = "R13";
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    rd(5); rd(6); rd(7);
    rd(1); rd(2); rd(3); rd(4);

    cur_req = "R1";
    rst = 1'b1; idle(2);
    rst = 1'b0; rd(2); rd(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule